// File: doc/BRIEF.md
# Two-Wire Configuration Register Port

This block is a two-wire serial slave that lets an external host configure a chip. The serial clock and data lines are sampled by the system clock, and the data line is driven with an open-drain style enable. A write transaction carries a command byte and then a value byte. The command byte either names a register directly, or works through an internal pointer: it can load the pointer, or write to the register the pointer holds.

Reads go only through the pointer. A read transaction returns two bytes. The first is a status byte and the second is the register contents. The status byte has a busy flag. After every register write, the flag stays set for a fixed number of clocks, which models the time the write takes to complete. A read that starts while the flag is set gets the busy status and no data.

The register file sits outside the block. The block reaches it through a simple bus: a write strobe, a read strobe, one shared address, write data, and read data that returns one clock after the read strobe.

Top module: `i2c_cfg_port`

## Requirements
- R1: After reset, sda_drive_low, reg_we and reg_re are low and busy is low.
- R2: The block pulls SDA low in the acknowledge slot when the address byte carries its own 7-bit address (DEV_ADDR), for both R/W=0 (write) and R/W=1 (read).
- R3: An address byte with any other address gets no acknowledge. SDA is then never driven until the next START.
- R4: Direct write. A command byte with bit 7 = 0, followed by a value byte, gives a single-cycle reg_we pulse that writes the value to register command[AW-1:0].
- R5: Indirect mode uses command bit 7 = 1, and command bits 5..0 are ignored. With bit 6 = 1, the value byte's bits [AW-1:0] are loaded into the pointer, and this does not set busy. With bit 6 = 0, the value byte is written to the register the pointer holds.
- R6: A read with R/W=1 returns the status byte first and then the contents of the register at the pointer. When no write is pending, the status byte is 0x01.
- R7: busy rises in the same cycle as reg_we and stays high for exactly BUSY_CYC cycles. A read whose address byte ends while busy is high returns status 0x80 (bit 7 = busy) and then the data byte 0x00.
- R8: A STOP or START before the value byte completes abandons the transfer without any register write. A START always begins a new address phase.
- R9: Every byte received after a matching write address is acknowledged. Bytes after the value byte have no effect.
- R10: After the master NACKs a read byte, SDA is released and stays released. Read bytes after the data byte return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | AW | Register address, shared by reads and writes |
| reg_wdata | output | 8 | Register write value |
| reg_rdata | input | 8 | Register read value, valid one cycle after reg_re |
| busy | output | 1 | Write completion pending |

## Verification
The hardest case to reach from the pins is a read that starts while a write is still completing. The busy window has to outlast a STOP, a START and a full address byte, and only then does the status byte show it. The bench sets BUSY_CYC longer than that sequence, issues the read right after the write's STOP, and then waits for busy to clear before reading the same register again to see the stored value. A second awkward case is aborting a transfer in the middle of a byte: the bench drives a repeated START after four bits and then checks that no write strobe or busy window followed.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} slv_state_t;
  localparam logic [7:0] STAT_BUSY  = 8'h80;
  localparam logic [7:0] STAT_READY = 8'h01;
  localparam logic [7:0] TX_FILL    = 8'hFF;
  localparam int IND_BIT = 7;
  localparam int PTR_BIT = 6;
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  localparam int LINES = 2;  // index 1 = SCL, index 0 = SDA
  logic [LINES-1:0] raw;
  logic [LINES-1:0] sync_q [STAGES];
  logic [LINES-1:0] last_q;
  logic [LINES-1:0] cur;

  assign raw = {scl_i, sda_i};
  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '1;
      last_q <= '1;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_s     <= 1'b1;
    end else begin
      scl_rise  <= cur[1] & ~last_q[1];
      scl_fall  <= ~cur[1] & last_q[1];
      start_det <= cur[1] & last_q[1] & last_q[0] & ~cur[0];
      stop_det  <= cur[1] & last_q[1] & ~last_q[0] & cur[0];
      sda_s     <= cur[0];
    end
  end
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_s,
  input  logic [7:0] tx_status,
  input  logic [7:0] tx_data,
  output logic       sda_oe,
  output logic       rx_stb,
  output logic [1:0] rx_idx,
  output logic [7:0] rx_byte,
  output logic       rd_req
);
  slv_state_t st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       rw, addr_ph;
  logic [1:0] byte_cnt, tx_cnt;
  logic [7:0] next_tx;

  always_comb begin
    case (tx_cnt)
      2'd0:    next_tx = tx_status;
      2'd1:    next_tx = tx_data;
      default: next_tx = TX_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sda_oe <= 1'b0; rx_stb <= 1'b0; rd_req <= 1'b0;
      rx_idx <= '0; rx_byte <= '0; bitcnt <= '0; sh <= '0;
      rw <= 1'b0; addr_ph <= 1'b0; byte_cnt <= '0; tx_cnt <= '0;
    end else begin
      rx_stb <= 1'b0;
      rd_req <= 1'b0;
      if (start_det) begin
        st <= S_RX; addr_ph <= 1'b1; bitcnt <= '0;
        byte_cnt <= '0; tx_cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (addr_ph) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1; st <= S_ACK; rw <= sh[0];
                  rd_req <= sh[0]; addr_ph <= 1'b0;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1; st <= S_ACK;
                rx_stb <= 1'b1; rx_idx <= byte_cnt; rx_byte <= sh;
                if (byte_cnt != 2'd2) byte_cnt <= byte_cnt + 2'd1;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sda_oe <= ~next_tx[7];
                sh <= {next_tx[6:0], 1'b1};
                if (tx_cnt != 2'd2) tx_cnt <= tx_cnt + 2'd1;
                st <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                sda_oe <= ~sh[7];
                sh <= {sh[6:0], 1'b1};
              end
            end
          end
          S_MACK: if (scl_rise) st <= sda_s ? S_IDLE : S_ACK;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3: an idle slave (including after a foreign address) never drives SDA
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);
  // R8: a STOP returns the slave to idle with SDA released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == S_IDLE && !sda_oe));
  // R10: during the master acknowledge slot SDA is released
  p_mack_release_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_MACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_cfg_regctl.sv
module i2c_cfg_regctl
  import i2c_cfg_pkg::*;
#(
  parameter int AW       = 7,   // at most 7: direct address comes from command bits
  parameter int BUSY_CYC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_stb,
  input  logic [1:0]    rx_idx,
  input  logic [7:0]    rx_byte,
  input  logic          rd_req,
  input  logic [7:0]    reg_rdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic [7:0]    tx_status,
  output logic [7:0]    tx_data,
  output logic          busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt;
  logic [7:0]    cmd;
  logic [AW-1:0] ptr;
  logic          fetch_q;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we <= 1'b0; reg_re <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      tx_status <= '0; tx_data <= '0; cnt <= '0; cmd <= '0;
      ptr <= '0; fetch_q <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      fetch_q <= reg_re;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (rx_stb && rx_idx == 2'd0) cmd <= rx_byte;
      if (rx_stb && rx_idx == 2'd1) begin
        if (!cmd[IND_BIT]) begin
          reg_we <= 1'b1; reg_addr <= cmd[AW-1:0];
          reg_wdata <= rx_byte; cnt <= CW'(BUSY_CYC);
        end else if (cmd[PTR_BIT]) begin
          ptr <= rx_byte[AW-1:0];
        end else begin
          reg_we <= 1'b1; reg_addr <= ptr;
          reg_wdata <= rx_byte; cnt <= CW'(BUSY_CYC);
        end
      end
      if (rd_req) begin
        if (busy) begin
          tx_status <= STAT_BUSY; tx_data <= '0;
        end else begin
          tx_status <= STAT_READY; reg_re <= 1'b1; reg_addr <= ptr;
        end
      end
      if (fetch_q) tx_data <= reg_rdata;
    end
  end

  // R4: write strobe is a single-cycle pulse
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  // R7: busy is up whenever a write strobe is issued
  p_busy_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> busy);
  // R7: a read starting during busy reports busy status
  p_busy_status_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy) |=> (tx_status == STAT_BUSY));
  // R5: loading the pointer never strobes a register write
  p_ptr_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && rx_idx == 2'd1 && cmd[IND_BIT] && cmd[PTR_BIT]) |=> !reg_we);
  // R6: read and write strobes never coincide
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));
endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         AW       = 7,
  parameter int         BUSY_CYC = 16,
  parameter int         STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          busy
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic rx_stb, rd_req;
  logic [1:0] rx_idx;
  logic [7:0] rx_byte, tx_status, tx_data;

  i2c_cfg_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_s(sda_s));

  i2c_cfg_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .tx_status(tx_status), .tx_data(tx_data), .sda_oe(sda_drive_low),
    .rx_stb(rx_stb), .rx_idx(rx_idx), .rx_byte(rx_byte), .rd_req(rd_req));

  i2c_cfg_regctl #(.AW(AW), .BUSY_CYC(BUSY_CYC)) u_regctl (
    .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_idx(rx_idx),
    .rx_byte(rx_byte), .rd_req(rd_req), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_status(tx_status), .tx_data(tx_data),
    .busy(busy));
endmodule

// File: tb/i2c_cfg_port_tb_top.sv
module i2c_cfg_port_tb_top;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int AW = 7;
  localparam int BUSY = 500;
  localparam int Q = 8;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic sda_line, sda_drive_low, reg_we, reg_re, busy;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, rdq;
  logic [7:0] mem [2**AW] = '{default: 8'h00};
  int exp_mem [2**AW];
  int n_chk = 0, n_fail = 0;
  logic bclr = 1'b0;
  int bcnt = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_drive_low;

  i2c_cfg_port #(.DEV_ADDR(DEV), .AW(AW), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdq), .busy(busy));

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) rdq <= mem[reg_addr];
  end

  always @(posedge clk) begin
    if (bclr) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(nack);
  endtask

  task automatic wr_tx(input logic [7:0] cmd, input logic [7:0] val, output int acks);
    logic a;
    acks = 0;
    i2c_start();
    send_byte({DEV, 1'b0}, a); acks += int'(a);
    send_byte(cmd, a); acks += int'(a);
    send_byte(val, a); acks += int'(a);
    i2c_stop();
  endtask

  task automatic rd_tx(output logic [7:0] st, output logic [7:0] d);
    logic a;
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, st);
    recv_byte(1'b1, d);
    i2c_stop();
  endtask

  task automatic ptr_read(input int p, input string tag);
    int acks;
    logic [7:0] st, d;
    wr_tx(8'hC0, 8'(p), acks);
    rd_tx(st, d);
    chk({tag, " status"}, st, 8'h01);
    chk({tag, " data"}, d, exp_mem[p]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acks;
    logic a;
    logic [7:0] st, d, ex;
    for (int i = 0; i < 2**AW; i++) exp_mem[i] = 0;
    wq(10); rst = 1'b0; wq(2);
    // R1: reset state
    chk("R1 sda_drive_low", sda_drive_low, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_re", reg_re, 0);
    chk("R1 busy", busy, 0);

    // R3: foreign addresses (one-bit neighbours and extremes) get no ack
    for (int k = 0; k < 9; k++) begin
      logic [6:0] fa;
      fa = (k < 7) ? (DEV ^ 7'(1 << k)) : ((k == 7) ? 7'h00 : 7'h7F);
      i2c_start();
      send_byte({fa, 1'b0}, a);
      chk("R3 foreign address ack", a, 0);
      send_byte(8'h00, a);
      chk("R3 later byte ack", a, 0);
      i2c_stop();
    end

    // R5 pointer load does not set busy; R7 busy window and read-while-busy
    wr_tx(8'hC0, 8'h05, acks);
    chk("R2 write acks", acks, 3);
    chk("R5 pointer load busy", busy, 0);
    bclr = 1'b1; wq(2); bclr = 1'b0;
    wr_tx(8'h05, 8'hA5, acks); exp_mem[5] = 8'hA5;
    rd_tx(st, d);
    chk("R7 status while busy", st, 8'h80);
    chk("R7 data while busy", d, 8'h00);
    wq(BUSY);
    chk("R7 busy cycles", bcnt, BUSY);
    rd_tx(st, d);
    chk("R6 status idle", st, 8'h01);
    chk("R6 data", d, 8'hA5);

    // R4: direct write sweep over even addresses
    for (int r = 0; r < 2**AW; r += 2) begin
      ex = 8'((r * 37 + 11) & 8'hFF);
      wr_tx(8'(r), ex, acks);
      exp_mem[r] = ex;
      if (r == 0) chk("R4 direct write acks", acks, 3);
    end
    wq(BUSY + 10);
    for (int k = 0; k < 16; k++) ptr_read(k * 8 + (k % 2), "R4 R6 readback");

    // R5: indirect write; command bits 5..0 ignored
    wr_tx(8'hC0, 8'h33, acks);
    wr_tx(8'h95, 8'h5C, acks); exp_mem[8'h33] = 8'h5C;
    wq(BUSY + 10);
    ptr_read(8'h33, "R5 indirect target");
    ptr_read(8'h15, "R5 no write to low bits");

    // R9: extra write bytes acked and ignored
    i2c_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h07, a);
    send_byte(8'h77, a); chk("R9 value ack", a, 1);
    send_byte(8'h99, a); chk("R9 extra ack", a, 1);
    send_byte(8'h44, a); chk("R9 second extra ack", a, 1);
    i2c_stop();
    exp_mem[7] = 8'h77;
    wq(BUSY + 10);
    ptr_read(7, "R9 extra ignored");

    // R8: STOP after command byte, START mid-byte
    i2c_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h09, a);
    i2c_stop(); wq(4);
    chk("R8 stop abort busy", busy, 0);
    i2c_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h09, a);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    i2c_start();
    chk("R8 start abort busy", busy, 0);
    send_byte({DEV, 1'b0}, a); chk("R8 new address ack", a, 1);
    send_byte(8'h0A, a); send_byte(8'h3C, a);
    i2c_stop(); exp_mem[8'h0A] = 8'h3C;
    wq(BUSY + 10);
    ptr_read(9, "R8 aborted target");
    ptr_read(8'h0A, "R8 after restart");

    // R10: extra read bytes are 0xFF; NACK releases SDA
    wr_tx(8'hC0, 8'h0A, acks);
    i2c_start();
    send_byte({DEV, 1'b1}, a); chk("R2 read address ack", a, 1);
    recv_byte(1'b0, st); recv_byte(1'b0, d);
    chk("R10 data before extra", d, 8'h3C);
    recv_byte(1'b1, d);
    chk("R10 extra read byte", d, 8'hFF);
    wq(Q);
    chk("R10 released after nack", sda_drive_low, 0);
    m_sda = 1'b1; bit_out(1'b1);
    chk("R10 stays released", sda_drive_low, 0);
    i2c_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule